// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block keeps track of the transmit credits a transaction layer may still spend. There are three traffic classes: completion, non-posted and posted. Each class has a header credit counter and a data credit counter, which makes six credit types. Software or a link-training sequencer loads the limits for all six types in one synchronous load. From then on the block counts single-cycle consumption pulses and single-credit return pulses. It publishes the remaining credits of every type. For a candidate packet, it also says whether that packet could be sent now.

Every counter is a pair of registers, a limit and an amount used, both in modulo arithmetic. Remaining credit is their difference, modulo the counter width. The send decision uses a wrap-aware comparison, so a counter that is overdrawn reads as short of credit rather than as full. A small controller has two states. ST_UNLOADED is entered on reset. ST_ACTIVE is entered through the LOAD_SEEN transition on the first load, and the controller stays there until reset.

Top module: `fcc_tracker`

## Requirements
- R1: While reset is held, and on its release, every remaining-credit field reads 0, and ready, can_send and cons_err are 0.
- R2: A load sets each header field to its lim_hdr slice and each data field to its lim_dat slice after one clock edge, and ready reads 1 from then on. Class k uses bits [k*HDR_W +: HDR_W] and [k*DAT_W +: DAT_W]. Class 0 is completion, class 1 is non-posted and class 2 is posted.
- R3: cons_vec bit 5 consumes one posted header credit. Bit 3 consumes one non-posted header credit and bit 1 one completion header credit. Each lone set bit lowers that header field by exactly 1 at the next edge.
- R4: Two patterns consume a data credit: bit 4 with bit 5 (posted), and bit 2 with bit 3 (non-posted). Bit 0 with bit 1 consumes completion data the same way. Each such pair lowers both the header and data fields of that class by 1.
- R5: An illegal pattern leaves every counter unchanged, and cons_err is 1 in the cycle that follows it and 0 otherwise. Illegal patterns are: more than one header bit, more than one data bit, or a data bit without the header bit of its own class.
- R6: Each set bit of rtn_vec raises the matching type's remaining credit by 1. rtn_vec uses the same bit layout as cons_vec.
- R7: When a load and a legal consume arrive in the same cycle, the consume is applied to the freshly loaded values.
- R8: can_send is 1 only when all of the following hold: the block is active, q_cls is 0, 1 or 2, and the class has one header credit and ceil(q_bytes/16) data credits available. Availability is tested as (remaining - need) mod 2^W <= 2^(W-1). q_cls = 3 never sends.
- R9: Before the first load, consume and return pulses change nothing and can_send stays 0.
- R10: Counters wrap modulo 2^HDR_W and 2^DAT_W. A data field consumed below zero reads 2^DAT_W - 1, and the class then cannot send even a zero-byte packet.
- R11: A return pulse arriving in the same cycle as a load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_load | input | 1 | Load all six limits this cycle |
| lim_hdr | input | 3*HDR_W | Header limits, class k at slice k |
| lim_dat | input | 3*DAT_W | Data limits in 16-byte units, class k at slice k |
| cons_vec | input | 6 | Consumption pulses |
| rtn_vec | input | 6 | Credit return pulses, one credit each |
| q_cls | input | 2 | Candidate packet class |
| q_bytes | input | BYTES_W | Candidate payload length in bytes |
| rem_hdr | output | 3*HDR_W | Remaining header credits per class |
| rem_dat | output | 3*DAT_W | Remaining data credits per class |
| ready | output | 1 | Limits have been loaded |
| can_send | output | 1 | Candidate packet fits now |
| cons_err | output | 1 | Previous cycle carried an illegal consumption pattern |

## Verification
The stability properties rely on the inputs being idle: they hold only when cons_vec and rtn_vec are zero and no load is pending. The illegal-pattern property also requires rtn_vec to be zero. The directed tasks keep those inputs at zero between stimulus cycles, so the properties are tested on exactly those idle cycles. The random task drives rtn_vec freely but never starts a load. Any ordering it produces is checked against the scoreboard rather than against those properties.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
    localparam int NCLS    = 3;
    localparam int UNIT_SH = 4;   // one data credit covers 16 bytes

    typedef enum logic {
        ST_UNLOADED,
        ST_ACTIVE
    } fcc_state_e;
endpackage

// File: rtl/fcc_cons_decode.sv
`timescale 1ns/1ps
module fcc_cons_decode (
    input  logic [5:0] vec,
    output logic       legal
);
    logic [2:0] hdr_bits;
    logic [2:0] dat_bits;

    always_comb begin
        hdr_bits = {vec[5], vec[3], vec[1]};
        dat_bits = {vec[4], vec[2], vec[0]};
        if (dat_bits != 3'b000) begin
            legal = $onehot(dat_bits) && (dat_bits == hdr_bits);
        end else begin
            legal = $onehot0(hdr_bits);
        end
    end
endmodule

// File: rtl/fcc_credit_ctr.sv
`timescale 1ns/1ps
module fcc_credit_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         live,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] need,
    output logic [W-1:0] rem,
    output logic         ok
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);

    logic [W-1:0] lim_q;
    logic [W-1:0] used_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= '0;
            used_q <= '0;
        end else if (load_en) begin
            lim_q  <= load_val;
            used_q <= {{(W-1){1'b0}}, dec};
        end else if (live) begin
            lim_q  <= lim_q  + {{(W-1){1'b0}}, inc};
            used_q <= used_q + {{(W-1){1'b0}}, dec};
        end
    end

    always_comb begin
        rem = lim_q - used_q;
        ok  = (rem - need) <= HALF;
    end
endmodule

// File: rtl/fcc_tracker.sv
`timescale 1ns/1ps
module fcc_tracker
    import fcc_pkg::*;
#(
    parameter int HDR_W   = 8,
    parameter int DAT_W   = 12,
    parameter int BYTES_W = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lim_load,
    input  logic [3*HDR_W-1:0]    lim_hdr,
    input  logic [3*DAT_W-1:0]    lim_dat,
    input  logic [5:0]            cons_vec,
    input  logic [5:0]            rtn_vec,
    input  logic [1:0]            q_cls,
    input  logic [BYTES_W-1:0]    q_bytes,
    output logic [3*HDR_W-1:0]    rem_hdr,
    output logic [3*DAT_W-1:0]    rem_dat,
    output logic                  ready,
    output logic                  can_send,
    output logic                  cons_err
);
    fcc_state_e state_q, state_d;

    logic               legal;
    logic               live;
    logic               apply;
    logic [BYTES_W:0]   padded;
    logic [DAT_W-1:0]   need_dat;
    logic [NCLS-1:0]    hok;
    logic [NCLS-1:0]    dok;
    logic               err_q;

    fcc_cons_decode u_dec (
        .vec   (cons_vec),
        .legal (legal)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNLOADED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: LOAD_SEEN takes ST_UNLOADED to ST_ACTIVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOADED: if (lim_load) state_d = ST_ACTIVE;
            ST_ACTIVE:   state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= !legal;
        end
    end

    always_comb begin
        padded   = {1'b0, q_bytes} + (BYTES_W+1)'(15);
        need_dat = DAT_W'(padded >> UNIT_SH);
        apply    = legal && (live || lim_load);
    end

    genvar k;
    generate
        for (k = 0; k < NCLS; k++) begin : g_cls
            fcc_credit_ctr #(.W(HDR_W)) u_hdr (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_en  (lim_load),
                .load_val (lim_hdr[k*HDR_W +: HDR_W]),
                .live     (live),
                .inc      (rtn_vec[2*k+1]),
                .dec      (cons_vec[2*k+1] & apply),
                .need     (HDR_W'(1)),
                .rem      (rem_hdr[k*HDR_W +: HDR_W]),
                .ok       (hok[k])
            );
            fcc_credit_ctr #(.W(DAT_W)) u_dat (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_en  (lim_load),
                .load_val (lim_dat[k*DAT_W +: DAT_W]),
                .live     (live),
                .inc      (rtn_vec[2*k]),
                .dec      (cons_vec[2*k] & apply),
                .need     (need_dat),
                .rem      (rem_dat[k*DAT_W +: DAT_W]),
                .ok       (dok[k])
            );
        end
    endgenerate

    // outputs
    always_comb begin
        live     = 1'b0;
        can_send = 1'b0;
        unique case (state_q)
            ST_UNLOADED: live = 1'b0;
            ST_ACTIVE: begin
                live = 1'b1;
                unique case (q_cls)
                    2'd0:    can_send = hok[0] & dok[0];
                    2'd1:    can_send = hok[1] & dok[1];
                    2'd2:    can_send = hok[2] & dok[2];
                    default: can_send = 1'b0;
                endcase
            end
        endcase
        ready    = live;
        cons_err = err_q;
    end
endmodule

// File: rtl/fcc_tracker_sva.sv
`timescale 1ns/1ps
module fcc_tracker_sva #(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lim_load,
    input logic [3*HDR_W-1:0] lim_hdr,
    input logic [3*DAT_W-1:0] lim_dat,
    input logic [5:0]         cons_vec,
    input logic [5:0]         rtn_vec,
    input logic [3*HDR_W-1:0] rem_hdr,
    input logic [3*DAT_W-1:0] rem_dat,
    input logic               ready,
    input logic               can_send,
    input logic               cons_err
);
    logic [2:0] hv;
    logic [2:0] dv;
    logic       bad;

    always_comb begin
        hv  = {cons_vec[5], cons_vec[3], cons_vec[1]};
        dv  = {cons_vec[4], cons_vec[2], cons_vec[0]};
        bad = ($countones(hv) > 1) || ($countones(dv) > 1) ||
              (($countones(dv) == 1) && (hv != dv));
    end

    // R5
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> cons_err);

    // R5
    good_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad |=> !cons_err);

    // R5
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && ready && !lim_load && rtn_vec == 6'd0)
        |=> ($stable(rem_hdr) && $stable(rem_dat)));

    // R9
    idle_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !can_send);

    // R2
    ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_load && cons_vec == 6'd0)
        |=> (rem_hdr == $past(lim_hdr) && rem_dat == $past(lim_dat)));

    // R3
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_load && cons_vec == 6'd0 && rtn_vec == 6'd0)
        |=> ($stable(rem_hdr) && $stable(rem_dat)));
endmodule

bind fcc_tracker fcc_tracker_sva #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .lim_load (lim_load),
    .lim_hdr  (lim_hdr),
    .lim_dat  (lim_dat),
    .cons_vec (cons_vec),
    .rtn_vec  (rtn_vec),
    .rem_hdr  (rem_hdr),
    .rem_dat  (rem_dat),
    .ready    (ready),
    .can_send (can_send),
    .cons_err (cons_err)
);

// File: tb/sim_fcc_tracker.sv
`timescale 1ns/1ps
module sim_fcc_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lim_load = 1'b0;
    logic [23:0] lim_hdr = '0;
    logic [35:0] lim_dat = '0;
    logic [5:0]  cons_vec = '0;
    logic [5:0]  rtn_vec = '0;
    logic [1:0]  q_cls = '0;
    logic [12:0] q_bytes = '0;
    logic [23:0] rem_hdr;
    logic [35:0] rem_dat;
    logic        ready, can_send, cons_err;

    int n_chk = 0;
    int n_bad = 0;

    // scoreboard: type t = cons_vec bit; odd = header, class = t/2
    int  m_lim  [6];
    int  m_used [6];
    bit  m_act;
    bit  m_err;

    always #2.5 clk = ~clk;

    fcc_tracker u0 (
        .clk(clk), .rst_n(rst_n), .lim_load(lim_load), .lim_hdr(lim_hdr),
        .lim_dat(lim_dat), .cons_vec(cons_vec), .rtn_vec(rtn_vec),
        .q_cls(q_cls), .q_bytes(q_bytes), .rem_hdr(rem_hdr),
        .rem_dat(rem_dat), .ready(ready), .can_send(can_send),
        .cons_err(cons_err)
    );

    function automatic int tmask(input int t);
        return (t % 2 == 1) ? 255 : 4095;
    endfunction

    function automatic int m_rem(input int t);
        return (m_lim[t] - m_used[t]) & tmask(t);
    endfunction

    function automatic bit legal_of(input logic [5:0] v);
        int nh = 0;
        int nd = 0;
        bit pair_ok = 1;
        for (int k = 0; k < 3; k++) begin
            nh += v[2*k+1];
            nd += v[2*k];
            if (v[2*k] && !v[2*k+1]) pair_ok = 0;
        end
        return (nh <= 1) && (nd <= 1) && pair_ok;
    endfunction

    function automatic bit m_can(input int cls, input int bytes);
        int need;
        bit hok, dok;
        if (!m_act || cls == 3) return 0;
        need = (bytes + 15) / 16;
        hok = ((m_rem(2*cls+1) - 1) & 255) <= 128;
        dok = ((m_rem(2*cls) - need) & 4095) <= 2048;
        return hok && dok;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int t = 0; t < 6; t++) begin
            if (t % 2 == 1) check(tag, int'(rem_hdr[(t/2)*8 +: 8]), m_rem(t));
            else            check(tag, int'(rem_dat[(t/2)*12 +: 12]), m_rem(t));
        end
        check(tag, int'(ready), int'(m_act));
        check(tag, int'(cons_err), int'(m_err));
    endtask

    // drive one cycle at negedge, update model at the edge, return at negedge
    task automatic step(input logic [5:0] cv, input logic [5:0] rv,
                        input logic ld, input logic [23:0] lh, input logic [35:0] ldd);
        bit lg;
        cons_vec = cv; rtn_vec = rv; lim_load = ld; lim_hdr = lh; lim_dat = ldd;
        @(posedge clk);
        lg = legal_of(cv);
        m_err = !lg;
        if (ld) begin
            for (int t = 0; t < 6; t++) begin
                m_lim[t]  = (t % 2 == 1) ? int'(lh[(t/2)*8 +: 8]) : int'(ldd[(t/2)*12 +: 12]);
                m_used[t] = (lg && cv[t]) ? 1 : 0;
            end
            m_act = 1;
        end else if (m_act) begin
            for (int t = 0; t < 6; t++) begin
                if (lg && cv[t]) m_used[t] = (m_used[t] + 1) & tmask(t);
                if (rv[t])       m_lim[t]  = (m_lim[t] + 1) & tmask(t);
            end
        end
        @(negedge clk);
        cons_vec = '0; rtn_vec = '0; lim_load = 0; lim_hdr = '0; lim_dat = '0;
        #1;
    endtask

    task automatic idle(); step(6'd0, 6'd0, 0, '0, '0); endtask

    task automatic ask(input string tag, input int cls, input int bytes);
        q_cls = 2'(cls); q_bytes = 13'(bytes);
        #1;
        check(tag, int'(can_send), int'(m_can(cls, bytes)));
    endtask

    task automatic load_std(input logic [5:0] cv, input logic [5:0] rv);
        // posted hdr 10 data 40, non-posted hdr 6 data 3, completion hdr 4 data 20
        step(cv, rv, 1, {8'd10, 8'd6, 8'd4}, {12'd40, 12'd3, 12'd20});
    endtask

    task automatic t_reset();
        check_all("R1 reset outputs");
        check("R1 can_send", int'(can_send), 0);
    endtask

    task automatic t_preload();
        step(6'b100000, 6'b111111, 0, '0, '0);
        check_all("R9 pre-load pulses ignored");
        ask("R9 no send before load", 2, 0);
    endtask

    task automatic t_load();
        load_std(6'd0, 6'd0);
        check_all("R2 load values");
        check("R2 posted hdr slice", int'(rem_hdr[23:16]), 10);
        check("R2 completion data slice", int'(rem_dat[11:0]), 20);
    endtask

    task automatic t_hdr_only();
        step(6'b100000, 6'd0, 0, '0, '0); check_all("R3 posted header");
        step(6'b001000, 6'd0, 0, '0, '0); check_all("R3 non-posted header");
        step(6'b000010, 6'd0, 0, '0, '0); check_all("R3 completion header");
        check("R3 completion hdr value", int'(rem_hdr[7:0]), 3);
    endtask

    task automatic t_pair();
        step(6'b110000, 6'd0, 0, '0, '0); check_all("R4 posted pair");
        step(6'b001100, 6'd0, 0, '0, '0); check_all("R4 non-posted pair");
        step(6'b000011, 6'd0, 0, '0, '0); check_all("R4 completion pair");
        check("R4 posted data value", int'(rem_dat[35:24]), 39);
    endtask

    task automatic t_illegal();
        step(6'b010000, 6'd0, 0, '0, '0); check_all("R5 data without header");
        check("R5 flag raised", int'(cons_err), 1);
        idle(); check("R5 flag clears", int'(cons_err), 0);
        step(6'b101000, 6'd0, 0, '0, '0); check_all("R5 two headers");
        step(6'b100001, 6'd0, 0, '0, '0); check_all("R5 cross-class pair");
        step(6'b110101, 6'd0, 0, '0, '0); check_all("R5 two data bits");
        idle(); check_all("R5 after illegal");
    endtask

    task automatic t_return();
        step(6'd0, 6'b111111, 0, '0, '0); check_all("R6 return all");
        step(6'd0, 6'b000100, 0, '0, '0); check_all("R6 return np data");
    endtask

    task automatic t_load_consume();
        load_std(6'b001100, 6'd0);
        check_all("R7 load with consume");
        check("R7 np data after", int'(rem_dat[23:12]), 2);
    endtask

    task automatic t_load_return();
        load_std(6'd0, 6'b111111);
        check_all("R11 return dropped on load");
        check("R11 posted hdr", int'(rem_hdr[23:16]), 10);
    endtask

    task automatic t_can_send();
        load_std(6'd0, 6'd0);
        ask("R8 np exact 48 bytes", 1, 48);
        ask("R8 np 49 bytes short", 1, 49);
        ask("R8 completion 320 fits", 0, 320);
        ask("R8 completion 321 short", 0, 321);
        ask("R8 posted zero bytes", 2, 0);
        ask("R8 class 3 never", 3, 0);
        for (int i = 0; i < 4; i++) step(6'b000010, 6'd0, 0, '0, '0);
        check_all("R8 completion headers spent");
        ask("R8 no header credit", 0, 0);
    endtask

    task automatic t_wrap();
        load_std(6'd0, 6'd0);
        for (int i = 0; i < 4; i++) step(6'b001100, 6'd0, 0, '0, '0);
        check_all("R10 np data overdrawn");
        check("R10 np data wraps", int'(rem_dat[23:12]), 4095);
        ask("R10 overdrawn zero-byte", 1, 0);
    endtask

    task automatic t_random();
        load_std(6'd0, 6'd0);
        for (int i = 0; i < 300; i++) begin
            int r = int'($urandom % 8);
            logic [5:0] cv;
            if (r == 0)      cv = 6'd0;
            else if (r <= 3) cv = 6'(2) << (2*(r-1));
            else if (r <= 6) cv = 6'(3) << (2*(r-4));
            else             cv = 6'($urandom);
            step(cv, 6'($urandom), 0, '0, '0);
            check_all("R3 R4 R6 random scoreboard");
            ask("R8 random query", int'($urandom % 4), int'($urandom % 1024));
        end
    endtask

    initial begin
        for (int t = 0; t < 6; t++) begin m_lim[t] = 0; m_used[t] = 0; end
        m_act = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        t_reset();
        rst_n = 1;
        #1;
        t_preload();
        t_load();
        t_hdr_only();
        t_pair();
        t_illegal();
        t_return();
        t_load_consume();
        t_load_return();
        t_can_send();
        t_wrap();
        t_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule